// File: doc/BRIEF.md
# Dual-Bank Indexed CMOS Register Port

This block is the host-facing side of a real-time-clock style CMOS space. A byte-wide I/O bus with an address, a read strobe, a write strobe, write data and read data reaches two 128-byte banks, called standard and extended. Each bank has its own pair of ports: an index port and a data port. The host first writes an index port to choose a location, then reads or writes the matching data port to move one byte.

The standard bank's first fourteen locations hold time, date and four configuration bytes. These belong to a separate timekeeping block. Data-port accesses that land there go out on a side interface, with an address, strobes and data, and do not touch the local array. The extended bank is general-purpose RAM on all 128 locations. It is always decoded and has no enable control. The RAM has no reset, which models battery backing. Only the index registers are reset.

The block has no sequential control states. Each host access is handled in the cycle it is presented. The only registered state is the two index registers and the two byte arrays.

Top module: `cmos_port`

## Requirements
- R1: There are two independent 128-byte banks. Bank location is taken from index bits 6:0, and index bit 7 never affects which byte is reached.
- R2: Port map, decoded from address bits 1:0 within the claimed window: 0x70 is the standard index, 0x71 the standard data, 0x72 the extended index and 0x73 the extended data.
- R3: Addresses 0x74, 0x75, 0x76 and 0x77 behave exactly as 0x70, 0x71, 0x72 and 0x73.
- R4: A data-port read returns the addressed byte combinationally in the same cycle. A data-port write updates that byte at the clock edge. Neither changes any index.
- R5: When the standard index selects location 0 to 13, a standard data access asserts `tk_rd` or `tk_wr` with `tk_addr` equal to the index. A read returns `tk_rdata`, and a write presents `io_wdata` on `tk_wdata`.
- R6: An index-port read returns the full 8-bit value last written to that port. Bit 7 of the standard index is driven on `std_idx_b7`.
- R7: Reset sets both index registers to 0x00. RAM contents survive reset.
- R8: An address outside 0x70 to 0x77 leaves `io_hit` low, reads as 0xFF and changes no state.
- R9: The extended bank is always decoded. Its locations 0 to 13 are local RAM and are never forwarded to the side interface.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for the index registers |
| io_addr | input | 16 | Host I/O address |
| io_rd | input | 1 | Host read strobe |
| io_wr | input | 1 | Host write strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, 0xFF when not claimed |
| io_hit | output | 1 | Access claimed by this block |
| std_idx_b7 | output | 1 | Latched bit 7 of the standard index |
| tk_addr | output | 4 | Side interface location |
| tk_rd | output | 1 | Side interface read strobe |
| tk_wr | output | 1 | Side interface write strobe |
| tk_wdata | output | 8 | Side interface write data |
| tk_rdata | input | 8 | Side interface read data |

## Verification
The bench sets index bit 7 and confirms that the same byte is still reached. A design that used all eight bits would address past the bank or alias the wrong byte. It checks the forwarding boundary at locations 13 and 14 in the standard bank, and at low locations in the extended bank. A wrong comparison or a missing bank check would either corrupt the timekeeping model or hide RAM behind it. It also resets the block between a write and its readback. A design that cleared RAM, or failed to clear an index, would return the wrong byte.

// File: rtl/cmos_pkg.sv
package cmos_pkg;
    typedef enum logic [1:0] {
        PK_STD_IDX = 2'd0,
        PK_STD_DAT = 2'd1,
        PK_EXT_IDX = 2'd2,
        PK_EXT_DAT = 2'd3
    } port_kind_t;

    function automatic logic kind_bank(port_kind_t k);
        return k[1];
    endfunction

    function automatic logic kind_is_data(port_kind_t k);
        return k[0];
    endfunction
endpackage

// File: rtl/cmos_decode.sv
module cmos_decode
    import cmos_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'h0070
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_o,
    output port_kind_t        kind_o
);
    localparam logic [ADDR_W-1:0] WIN_MASK = ADDR_W'(7);

    always_comb begin
        hit_o  = ((addr | WIN_MASK) == (BASE | WIN_MASK));
        kind_o = port_kind_t'(addr[1:0]);
    end
endmodule

// File: rtl/cmos_index.sv
module cmos_index #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata;
    end
endmodule

// File: rtl/cmos_bank.sv
module cmos_bank #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/cmos_port.sv
module cmos_port
    import cmos_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int BANK_DEPTH = 128,
    parameter int TK_SPAN    = 14,
    parameter logic [ADDR_W-1:0] BASE = 16'h0070
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_hit,
    output logic              std_idx_b7,
    output logic [3:0]        tk_addr,
    output logic              tk_rd,
    output logic              tk_wr,
    output logic [DATA_W-1:0] tk_wdata,
    input  logic [DATA_W-1:0] tk_rdata
);
    localparam int IDX_W = $clog2(BANK_DEPTH);
    localparam int NBANK = 2;
    localparam int TK_AW = 4;

    logic       dec_hit;
    port_kind_t kind;

    logic [NBANK-1:0][DATA_W-1:0] idx_q;
    logic [NBANK-1:0][DATA_W-1:0] ram_q;
    logic [NBANK-1:0]             idx_we;
    logic [NBANK-1:0]             ram_we;
    logic                         side_sel;
    logic                         fwd;

    cmos_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .addr  (io_addr),
        .hit_o (dec_hit),
        .kind_o(kind)
    );

    assign side_sel = (idx_q[0][IDX_W-1:0] < IDX_W'(TK_SPAN));
    assign fwd      = dec_hit && (kind == PK_STD_DAT) && side_sel;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_comb begin
            idx_we[b] = io_wr && dec_hit && !kind_is_data(kind)
                        && (kind_bank(kind) == 1'(b));
            ram_we[b] = io_wr && dec_hit && kind_is_data(kind)
                        && (kind_bank(kind) == 1'(b))
                        && !((b == 0) && side_sel);
        end

        cmos_index #(.W(DATA_W)) u_idx (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (idx_we[b]),
            .wdata(io_wdata),
            .q    (idx_q[b])
        );

        cmos_bank #(.DEPTH(BANK_DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ram (
            .clk  (clk),
            .we   (ram_we[b]),
            .idx  (idx_q[b][IDX_W-1:0]),
            .wdata(io_wdata),
            .rdata(ram_q[b])
        );
    end

    always_comb begin
        io_hit   = dec_hit && (io_rd || io_wr);
        io_rdata = '1;
        if (io_rd && dec_hit) begin
            unique case (kind)
                PK_STD_IDX: io_rdata = idx_q[0];
                PK_STD_DAT: io_rdata = fwd ? tk_rdata : ram_q[0];
                PK_EXT_IDX: io_rdata = idx_q[1];
                PK_EXT_DAT: io_rdata = ram_q[1];
                default:    io_rdata = '1;
            endcase
        end
    end

    assign std_idx_b7 = idx_q[0][DATA_W-1];
    assign tk_addr    = idx_q[0][TK_AW-1:0];
    assign tk_rd      = io_rd && fwd;
    assign tk_wr      = io_wr && fwd;
    assign tk_wdata   = io_wdata;
endmodule

// File: rtl/cmos_port_chk.sv
module cmos_port_chk #(
    parameter int DATA_W  = 8,
    parameter int TK_SPAN = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        addr_lo,
    input logic              io_rd,
    input logic              io_wr,
    input logic [DATA_W-1:0] io_wdata,
    input logic [DATA_W-1:0] io_rdata,
    input logic              io_hit,
    input logic [3:0]        tk_addr,
    input logic              tk_rd,
    input logic              tk_wr,
    input logic [DATA_W-1:0] std_idx,
    input logic [DATA_W-1:0] ext_idx
);
    AST_MISS_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_hit) |-> (io_rdata == '1)); // R8

    AST_MISS_KEEPS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !io_hit) |=> ($stable(std_idx) && $stable(ext_idx))); // R8

    AST_DATA_KEEPS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (io_hit && addr_lo[0]) |=> ($stable(std_idx) && $stable(ext_idx))); // R4

    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_hit && addr_lo == 2'b00) |=> (std_idx == $past(io_wdata))); // R6

    AST_SIDE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (tk_rd || tk_wr) |-> (32'(tk_addr) < TK_SPAN)); // R5

    AST_SIDE_STD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (tk_rd || tk_wr) |-> (io_hit && addr_lo == 2'b01)); // R9
endmodule

bind cmos_port cmos_port_chk #(.DATA_W(DATA_W), .TK_SPAN(TK_SPAN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_lo (io_addr[1:0]),
    .io_rd   (io_rd),
    .io_wr   (io_wr),
    .io_wdata(io_wdata),
    .io_rdata(io_rdata),
    .io_hit  (io_hit),
    .tk_addr (tk_addr),
    .tk_rd   (tk_rd),
    .tk_wr   (tk_wr),
    .std_idx (idx_q[0]),
    .ext_idx (idx_q[1])
);

// File: tb/cmos_port_tb.sv
module cmos_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_hit;
    logic        std_idx_b7;
    logic [3:0]  tk_addr;
    logic        tk_rd, tk_wr;
    logic [7:0]  tk_wdata, tk_rdata;

    logic [7:0]  tk_mem [14];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    cmos_port u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_hit(io_hit),
        .std_idx_b7(std_idx_b7), .tk_addr(tk_addr), .tk_rd(tk_rd), .tk_wr(tk_wr),
        .tk_wdata(tk_wdata), .tk_rdata(tk_rdata)
    );

    // external timekeeping model
    assign tk_rdata = (tk_addr < 4'd14) ? tk_mem[tk_addr] : 8'h00;
    always @(posedge clk) if (tk_wr && tk_addr < 4'd14) tk_mem[tk_addr] <= tk_wdata;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d, output logic h);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        d = io_rdata; h = io_hit;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        logic [7:0] d; logic h;
        io_read(16'h0070, d, h); check("R7 std index after reset", d, 8'h00);
        check("R2 hit on 0x70", {7'd0, h}, 8'h01);
        io_read(16'h0072, d, h); check("R7 ext index after reset", d, 8'h00);
        check("R7 b7 after reset", {7'd0, std_idx_b7}, 8'h00);
    endtask

    task automatic t_ext_bank();
        logic [7:0] d; logic h;
        for (int k = 0; k < 128; k += 9) begin
            io_write(16'h0072, 8'(k)); io_write(16'h0073, 8'(k ^ 8'hA3));
        end
        io_write(16'h0072, 8'd127); io_write(16'h0073, 8'h7E);
        for (int k = 0; k < 128; k += 9) begin
            io_write(16'h0072, 8'(k)); io_read(16'h0073, d, h);
            check("R1 ext bank readback", d, 8'(k ^ 8'hA3));
        end
        io_write(16'h0072, 8'd127); io_read(16'h0073, d, h);
        check("R4 ext top location", d, 8'h7E);
        io_read(16'h0072, d, h);
        check("R4 index kept after data access", d, 8'd127);
    endtask

    task automatic t_std_bank_bit7();
        logic [7:0] d; logic h;
        io_write(16'h0070, 8'd20); io_write(16'h0071, 8'h5C);
        io_write(16'h0070, 8'h94); io_read(16'h0071, d, h);
        check("R1 bit7 ignored for location", d, 8'h5C);
        check("R6 std_idx_b7 set", {7'd0, std_idx_b7}, 8'h01);
        io_read(16'h0070, d, h); check("R6 index readback", d, 8'h94);
        io_write(16'h0072, 8'hC5); io_read(16'h0072, d, h);
        check("R6 ext index readback", d, 8'hC5);
        io_write(16'h0072, 8'd40); io_write(16'h0073, 8'h44);
        io_write(16'h0070, 8'd40); io_write(16'h0071, 8'h33);
        io_read(16'h0073, d, h); check("R1 banks independent ext", d, 8'h44);
        io_read(16'h0071, d, h); check("R1 banks independent std", d, 8'h33);
    endtask

    task automatic t_alias();
        logic [7:0] d; logic h;
        io_write(16'h0074, 8'd30); io_write(16'h0075, 8'h5A);
        io_write(16'h0070, 8'd30); io_read(16'h0071, d, h);
        check("R3 alias 0x74/0x75 write", d, 8'h5A);
        io_read(16'h0074, d, h); check("R3 alias 0x74 index read", d, 8'd30);
        io_write(16'h0076, 8'd60); io_write(16'h0077, 8'hE1);
        io_write(16'h0072, 8'd60); io_read(16'h0077, d, h);
        check("R3 alias 0x76/0x77", d, 8'hE1);
        io_read(16'h0073, d, h); check("R3 alias equals base", d, 8'hE1);
    endtask

    task automatic t_side();
        logic [7:0] d; logic h;
        tk_mem[7] = 8'h3E;
        io_write(16'h0070, 8'd7); io_read(16'h0071, d, h);
        check("R5 side read", d, 8'h3E);
        io_write(16'h0070, 8'd3); io_write(16'h0071, 8'hC3);
        check("R5 side write", tk_mem[3], 8'hC3);
        io_write(16'h0070, 8'd13); io_write(16'h0071, 8'hD0);
        check("R5 side top location", tk_mem[13], 8'hD0);
        io_write(16'h0070, 8'd14); io_write(16'h0071, 8'h1E);
        io_read(16'h0071, d, h); check("R5 location 14 local", d, 8'h1E);
        io_write(16'h0072, 8'd3); io_write(16'h0073, 8'h11);
        check("R9 ext low not forwarded", tk_mem[3], 8'hC3);
        io_read(16'h0073, d, h); check("R9 ext low is RAM", d, 8'h11);
    endtask

    task automatic t_unclaimed();
        logic [7:0] d; logic h;
        io_write(16'h0070, 8'd20);
        io_read(16'h0080, d, h); check("R8 miss data", d, 8'hFF);
        check("R8 miss hit", {7'd0, h}, 8'h00);
        io_read(16'h006F, d, h); check("R8 0x6F data", d, 8'hFF);
        io_read(16'h0170, d, h); check("R8 0x170 hit", {7'd0, h}, 8'h00);
        io_write(16'h0078, 8'h55); io_write(16'h0170, 8'h66);
        io_read(16'h0070, d, h); check("R8 index untouched", d, 8'd20);
    endtask

    task automatic t_retention();
        logic [7:0] d; logic h;
        io_write(16'h0072, 8'd50); io_write(16'h0073, 8'hA5);
        io_write(16'h0070, 8'hB2);
        do_reset();
        io_read(16'h0072, d, h); check("R7 ext index cleared", d, 8'h00);
        io_read(16'h0070, d, h); check("R7 std index cleared", d, 8'h00);
        io_write(16'h0072, 8'd50); io_read(16'h0073, d, h);
        check("R7 RAM retained", d, 8'hA5);
    endtask

    initial begin
        for (int i = 0; i < 14; i++) tk_mem[i] = 8'(i * 17);
        do_reset();
        t_reset_state();
        t_ext_bank();
        t_std_bank_bit7();
        t_alias();
        t_side();
        t_unclaimed();
        t_retention();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule